// File: doc/BRIEF.md
# Memory Access Window Timer

This block times CPU memory accesses against a 14 MHz master clock. When a request arrives while it is idle, it opens an access window. The window's length depends on the region the access targets. It marks the first cycle of the window with a start pulse and holds an active level for the whole window. It ends a CPU-serving window with a single-cycle ready pulse.

Fast regions (main RAM and ROM) take short windows. The slow region, on the video side, takes long windows. Every 64th slow window is stretched by two cycles so that the video timing stays locked to the colour subcarrier. Main RAM also loses one slot in ten to DRAM refresh. When refresh falls due, the block runs a refresh slot with the refresh output high and then serves the waiting RAM access in the slot that follows.

Two internal counts set the window lengths: one counts completed slow windows and the other counts RAM slots. A synchronous reset clears both. Address decoding, data movement and the DRAM itself are outside this block.

Top module: `mem_window_timer`

## Requirements
- R1: A window begins only on a clock edge where `req` is high and the block is idle. `win_start` is high for exactly the first cycle of each window, and `win_active` is high for every cycle of every window.
- R2: A ROM access (`region` = 2'b01) has a window of 5 cycles, and `ready` is high in the 5th cycle.
- R3: A fast RAM access (`region` = 2'b00) with no refresh due has a window of 5 cycles, and `ready` is high in the 5th cycle.
- R4: A slow access (`region` = 2'b10 or 2'b11) has a window of 14 cycles, except as R5 states.
- R5: Slow windows are numbered from 0 after reset. Window number k, where k mod 64 = 63, lasts 16 cycles instead of 14.
- R6: ROM and RAM accesses leave the slow-window numbering unchanged. ROM and slow accesses leave the RAM slot numbering unchanged.
- R7: RAM accesses are numbered from 0 after reset. Access n, where n > 0 and n mod 9 = 0, is preceded by a 5-cycle refresh slot. In that slot `refresh` and `win_active` are high, `win_start` pulses in its first cycle, and `ready` stays low. A second `win_start` then opens the 5-cycle access slot, so `ready` comes 10 cycles after the request is sampled. Ten RAM slots therefore hold nine accesses and one refresh.
- R8: `ready` is high for one cycle only. In the cycle after `ready`, `win_active` is low, and a request is sampled at the end of that cycle.
- R9: A synchronous reset `rst` ends any window. All outputs are low in the cycle after reset, and both numberings restart from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 14 MHz master clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, sampled while idle |
| region | input | 2 | Target: 00 RAM, 01 ROM, 1x slow |
| win_start | output | 1 | First cycle of a window |
| win_active | output | 1 | A window is in progress |
| ready | output | 1 | Last cycle of a CPU-serving window |
| refresh | output | 1 | A refresh slot is in progress |

## Verification
A wrong slow-window count shows up as a stretched window at the wrong place. The fault can stay hidden for up to 63 slow windows, so the bench runs more than 64 slow accesses in a row after reset and checks the length of each one. A wrong RAM slot count moves the refresh slot or drops it. That is visible within ten RAM accesses as a 10-cycle access where a 5-cycle one was expected, or the reverse. Region misdecoding or a wrong window counter changes the ready position on the very next access.

// File: rtl/mem_window_timer.sv
module mem_window_timer #(
  parameter int FAST_LEN       = 5,
  parameter int SLOW_LEN       = 14,
  parameter int LONG_LEN       = 16,
  parameter int SLOW_PERIOD    = 64,
  parameter int REFRESH_PERIOD = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [1:0] region,
  output logic       win_start,
  output logic       win_active,
  output logic       ready,
  output logic       refresh
);
  localparam int CW = $clog2(LONG_LEN + 1);
  localparam int SW = $clog2(SLOW_PERIOD);
  localparam int RW = $clog2(REFRESH_PERIOD);
  localparam logic [CW-1:0] FAST_LAST = CW'(FAST_LEN - 1);
  localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_LEN - 1);
  localparam logic [CW-1:0] LONG_LAST = CW'(LONG_LEN - 1);
  localparam logic [SW-1:0] SLOW_WRAP = SW'(SLOW_PERIOD - 1);
  localparam logic [RW-1:0] REF_SLOT  = RW'(REFRESH_PERIOD - 1);

  logic          busy, is_slow, is_ram, in_ref;
  logic [CW-1:0] cnt;
  logic [SW-1:0] slow_no;
  logic [RW-1:0] ram_slot;
  logic [CW-1:0] last;
  logic          at_end;

  assign last = !is_slow ? FAST_LAST : (slow_no == SLOW_WRAP ? LONG_LAST : SLOW_LAST);
  assign at_end     = busy && (cnt == last);
  assign win_active = busy;
  assign win_start  = busy && (cnt == '0);
  assign ready      = at_end && !in_ref;
  assign refresh    = busy && in_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      is_slow  <= 1'b0;
      is_ram   <= 1'b0;
      in_ref   <= 1'b0;
      cnt      <= '0;
      slow_no  <= '0;
      ram_slot <= '0;
    end else if (!busy) begin
      if (req) begin
        busy    <= 1'b1;
        cnt     <= '0;
        is_slow <= region[1];
        is_ram  <= (region == 2'b00);
        in_ref  <= (region == 2'b00) && (ram_slot == REF_SLOT);
      end
    end else if (at_end) begin
      cnt <= '0;
      if (in_ref) begin
        in_ref   <= 1'b0;
        ram_slot <= '0;
      end else begin
        busy <= 1'b0;
        if (is_ram) ram_slot <= ram_slot + 1'b1;
        if (is_slow) slow_no <= (slow_no == SLOW_WRAP) ? '0 : slow_no + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r1_start_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(win_active) |-> $past(req));
  a_r8_ready_single: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);
  a_r8_idle_after_ready: assert property (@(posedge clk) disable iff (rst)
    ready |=> !win_active);
  a_r7_refresh_then_access: assert property (@(posedge clk) disable iff (rst)
    $fell(refresh) |-> (win_start && win_active));
  a_r5_long_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (ready && is_slow && cnt == LONG_LAST) |-> (slow_no == SLOW_WRAP));
endmodule

// File: tb/mem_window_timer_bench.sv
module mem_window_timer_bench;
  logic clk = 1'b0, rst = 1'b1, req = 1'b0;
  logic [1:0] region = 2'b00;
  logic win_start, win_active, ready, refresh;
  int checks = 0, fails = 0;
  int slow_n = 0, ram_n = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mem_window_timer u_mem_window_timer (
    .clk(clk), .rst(rst), .req(req), .region(region),
    .win_start(win_start), .win_active(win_active), .ready(ready), .refresh(refresh));

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] r, input int sn, input int rn);
    if (r[1]) return (sn % 64 == 63) ? 16 : 14;
    if (r == 2'b00 && rn > 0 && rn % 9 == 0) return 10;
    return 5;
  endfunction

  task automatic access(input logic [1:0] r);
    int cyc = 0, refc = 0, starts = 0, readys = 0, act_low = 0;
    int exp_l = exp_len(r, slow_n, ram_n);
    req = 1'b1; region = r;
    while (cyc < 40) begin
      @(negedge clk);
      cyc++;
      if (!win_active) act_low++;
      if (refresh) refc++;
      if (win_start) starts++;
      if (ready) begin readys++; break; end
    end
    req = 1'b0;
    if (r[1]) begin
      check(exp_l == 16 ? "R5 long slow length" : "R4 slow length", cyc, exp_l);
      slow_n++;
    end else if (r == 2'b01) begin
      check("R2 rom length", cyc, exp_l);
    end else begin
      check(exp_l == 10 ? "R7 ram+refresh length" : "R3 ram length", cyc, exp_l);
      check("R7 refresh cycles", refc, exp_l == 10 ? 5 : 0);
      ram_n++;
    end
    check("R1 start pulses", starts, exp_l == 10 ? 2 : 1);
    check("R1 active throughout", act_low, 0);
    check("R8 ready seen once", readys, 1);
    @(negedge clk);
    check("R8 idle after ready", {31'd0, win_active}, 0);
    check("R8 ready single", {31'd0, ready}, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; req = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    slow_n = 0; ram_n = 0;
    check("R9 outputs low after reset", {28'd0, win_start, win_active, ready, refresh}, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1 no window without req", {31'd0, win_active}, 0);
    end
    // R5 and R6: slow run with ROM/RAM mixed in, stretch lands on the 64th slow window
    for (int i = 0; i < 70; i++) begin
      access(2'b10);
      if (i % 7 == 3) access(2'b01);
      if (i % 11 == 5) access(2'b00);
    end
    // R7 and R6: RAM run with ROM and slow accesses between
    for (int i = 0; i < 30; i++) begin
      access(2'b00);
      if (i % 4 == 1) access(2'b01);
      if (i % 5 == 2) access(2'b11);
    end
    // R9: reset in the middle of a slow window restarts both numberings
    req = 1'b1; region = 2'b10;
    for (int i = 0; i < 6; i++) @(negedge clk);
    do_reset();
    @(negedge clk);
    check("R9 no window after reset", {31'd0, win_active}, 0);
    for (int i = 0; i < 10; i++) access(2'b00);
    for (int i = 0; i < 64; i++) access(2'b10);
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        check("R1 idle without req", {31'd0, win_active}, 0);
      end
      access(2'($urandom_range(0, 3)));
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule